// File: doc/BRIEF.md
# Resonance Sweep Peak Digitizer

This block runs a stepped frequency sweep for an external excitation source. It takes one amplitude reading from an external current-measurement ADC at each step. A resonant structure on a board draws the most current where its impedance is lowest. The block keeps track of the step that produced the largest reading. When the sweep ends, it reports that step's position as an N-bit signature word.

A sweep has 2^N steps. The frequency code for step k is the configured base plus k times the configured increment. The lowest frequency of the sweep therefore maps to code zero and the highest to code all ones. After each new frequency is applied, the block waits a programmable settle time, then requests a sample and stalls until the ADC supplies it. A single-cycle `done` pulse marks the end of a sweep. The signature stays on its output until the next sweep completes.

Top module: `res_sweep_peak`

## Requirements
- R1: After reset, `freq_code` is 0, `adc_req` is 0, `done` is 0 and `sig_code` is 0.
- R2: A `start` seen while no sweep is running loads `freq_code` with `cfg_fmin` in the following cycle. Each accepted sample that is not the last one adds `cfg_fstep` to `freq_code`, modulo 2^FREQ_W. A sweep accepts exactly 2^CODE_BITS samples.
- R3: Each time a step's frequency is applied, `adc_req` stays low for `cfg_settle`+1 clock cycles and then goes high.
- R4: `adc_req` stays high and `freq_code` holds its value until a cycle in which `adc_valid` is high. `adc_amp` is taken only in a cycle where both `adc_req` and `adc_valid` are high. `adc_valid` has no effect while `adc_req` is low.
- R5: `sig_code` becomes the step index (0 for the first sample) of the largest amplitude seen in the sweep. If several steps share that largest amplitude, the lowest index among them is reported.
- R6: A peak at the first step gives `sig_code` = 0. A peak at the last step gives `sig_code` = 2^CODE_BITS-1 (all ones).
- R7: `done` is high for exactly one cycle, the cycle after the last sample is accepted. `adc_req` is low in that cycle.
- R8: `sig_code` changes only in the cycle in which `done` is high, and holds its value at all other times.
- R9: A `start` during a sweep is ignored, including one in the same cycle as the last sample's acceptance. A `start` in the `done` cycle begins a new sweep.
- R10: `cfg_fmin`, `cfg_fstep` and `cfg_settle` are captured when a sweep begins. Changing them during the sweep has no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep when idle |
| cfg_fmin | input | FREQ_W | Frequency code of step 0 |
| cfg_fstep | input | FREQ_W | Code increment between steps |
| cfg_settle | input | SETTLE_W | Settle length; the wait is this value plus one cycle |
| freq_code | output | FREQ_W | Frequency code to the excitation source |
| adc_req | output | 1 | Sample requested for the current step |
| adc_valid | input | 1 | ADC sample present |
| adc_amp | input | AMP_W | Current amplitude sample |
| done | output | 1 | One-cycle end-of-sweep pulse |
| sig_code | output | CODE_BITS | Step index of the peak |

## Verification
Acceptance of the final sample and a new `start` can land in the same cycle. The bench also puts a `start` in the `done` cycle that immediately follows. Both cases are provoked by holding `start` high through the end of a sweep. The cycle-by-cycle model then expects the first `start` to be dropped and the second to begin a fresh sweep from `cfg_fmin`, which gives two `done` pulses and a matching code. Stray `adc_valid` pulses carrying a maximal amplitude during settle cycles show whether sampling outside a request corrupts the peak.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int DEF_CODE_BITS = 4;
    localparam int DEF_FREQ_W    = 16;
    localparam int DEF_AMP_W     = 12;
    localparam int DEF_SETTLE_W  = 8;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_SETTLE = 2'd1,
        SW_SAMPLE = 2'd2
    } sweep_state_t;

endpackage

// File: rtl/rsp_sequencer.sv
module rsp_sequencer
    import rsp_pkg::*;
#(
    parameter int CODE_BITS = DEF_CODE_BITS,
    parameter int FREQ_W    = DEF_FREQ_W,
    parameter int SETTLE_W  = DEF_SETTLE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [FREQ_W-1:0]    cfg_fmin,
    input  logic [FREQ_W-1:0]    cfg_fstep,
    input  logic [SETTLE_W-1:0]  cfg_settle,
    input  logic                 adc_valid,
    output logic [FREQ_W-1:0]    freq_code,
    output logic                 adc_req,
    output logic                 smp_take,
    output logic [CODE_BITS-1:0] smp_idx,
    output logic                 smp_last,
    output logic                 sweep_end
);
    localparam logic [CODE_BITS-1:0] LAST_STEP = {CODE_BITS{1'b1}};

    typedef struct packed {
        logic [FREQ_W-1:0]   fstep;
        logic [SETTLE_W-1:0] settle;
    } sweep_cfg_t;

    sweep_state_t         state_q;
    sweep_cfg_t           cfg_q;
    logic [CODE_BITS-1:0] step_q;
    logic [SETTLE_W-1:0]  wait_q;
    logic [FREQ_W-1:0]    freq_q;
    logic                 end_q;

    assign adc_req   = (state_q == SW_SAMPLE);
    assign smp_take  = adc_req && adc_valid;
    assign smp_idx   = step_q;
    assign smp_last  = (step_q == LAST_STEP);
    assign freq_code = freq_q;
    assign sweep_end = end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            cfg_q   <= '0;
            step_q  <= '0;
            wait_q  <= '0;
            freq_q  <= '0;
            end_q   <= 1'b0;
        end else begin
            end_q <= 1'b0;
            unique case (state_q)
                SW_IDLE: begin
                    if (start) begin
                        state_q      <= SW_SETTLE;
                        step_q       <= '0;
                        freq_q       <= cfg_fmin;
                        cfg_q.fstep  <= cfg_fstep;
                        cfg_q.settle <= cfg_settle;
                        wait_q       <= cfg_settle;
                    end
                end
                SW_SETTLE: begin
                    if (wait_q == '0) begin
                        state_q <= SW_SAMPLE;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                SW_SAMPLE: begin
                    if (adc_valid) begin
                        if (smp_last) begin
                            state_q <= SW_IDLE;
                            end_q   <= 1'b1;
                        end else begin
                            state_q <= SW_SETTLE;
                            step_q  <= step_q + 1'b1;
                            freq_q  <= freq_q + cfg_q.fstep;
                            wait_q  <= cfg_q.settle;
                        end
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rsp_peak_track.sv
module rsp_peak_track
    import rsp_pkg::*;
#(
    parameter int CODE_BITS = DEF_CODE_BITS,
    parameter int AMP_W     = DEF_AMP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_take,
    input  logic [CODE_BITS-1:0] smp_idx,
    input  logic                 smp_last,
    input  logic [AMP_W-1:0]     smp_amp,
    output logic [CODE_BITS-1:0] sig_code
);
    typedef struct packed {
        logic [AMP_W-1:0]     amp;
        logic [CODE_BITS-1:0] idx;
    } peak_t;

    peak_t                best_q;
    logic [CODE_BITS-1:0] code_q;
    logic                 wins;
    logic [CODE_BITS-1:0] win_idx;

    // strict compare keeps the earlier step on a tie; step 0 always seeds
    assign wins    = (smp_idx == '0) || (smp_amp > best_q.amp);
    assign win_idx = wins ? smp_idx : best_q.idx;
    assign sig_code = code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q <= '0;
            code_q <= '0;
        end else if (smp_take) begin
            if (wins) begin
                best_q.amp <= smp_amp;
                best_q.idx <= smp_idx;
            end
            if (smp_last) begin
                code_q <= win_idx;
            end
        end
    end
endmodule

// File: rtl/res_sweep_peak.sv
module res_sweep_peak
    import rsp_pkg::*;
#(
    parameter int CODE_BITS = DEF_CODE_BITS,
    parameter int FREQ_W    = DEF_FREQ_W,
    parameter int AMP_W     = DEF_AMP_W,
    parameter int SETTLE_W  = DEF_SETTLE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [FREQ_W-1:0]    cfg_fmin,
    input  logic [FREQ_W-1:0]    cfg_fstep,
    input  logic [SETTLE_W-1:0]  cfg_settle,
    output logic [FREQ_W-1:0]    freq_code,
    output logic                 adc_req,
    input  logic                 adc_valid,
    input  logic [AMP_W-1:0]     adc_amp,
    output logic                 done,
    output logic [CODE_BITS-1:0] sig_code
);
    logic                 take;
    logic [CODE_BITS-1:0] idx;
    logic                 last;

    rsp_sequencer #(
        .CODE_BITS(CODE_BITS),
        .FREQ_W   (FREQ_W),
        .SETTLE_W (SETTLE_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_fmin  (cfg_fmin),
        .cfg_fstep (cfg_fstep),
        .cfg_settle(cfg_settle),
        .adc_valid (adc_valid),
        .freq_code (freq_code),
        .adc_req   (adc_req),
        .smp_take  (take),
        .smp_idx   (idx),
        .smp_last  (last),
        .sweep_end (done)
    );

    rsp_peak_track #(
        .CODE_BITS(CODE_BITS),
        .AMP_W    (AMP_W)
    ) u_peak (
        .clk     (clk),
        .rst     (rst),
        .smp_take(take),
        .smp_idx (idx),
        .smp_last(last),
        .smp_amp (adc_amp),
        .sig_code(sig_code)
    );
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
    parameter int CODE_BITS = 4,
    parameter int FREQ_W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 adc_req,
    input logic                 adc_valid,
    input logic [FREQ_W-1:0]    freq_code,
    input logic                 done,
    input logic [CODE_BITS-1:0] sig_code
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R7

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        done |-> !adc_req);                                                // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (adc_req && !adc_valid) |=> (adc_req && $stable(freq_code)));      // R4

    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(sig_code));                                      // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (adc_req && start && !adc_valid) |=> adc_req);                     // R9
endmodule

bind res_sweep_peak rsp_checker #(
    .CODE_BITS(CODE_BITS),
    .FREQ_W   (FREQ_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .adc_req  (adc_req),
    .adc_valid(adc_valid),
    .freq_code(freq_code),
    .done     (done),
    .sig_code (sig_code)
);

// File: tb/res_sweep_peak_test.sv
module res_sweep_peak_test;
    localparam int CLK_PERIOD = 10;
    localparam int CB = 4;
    localparam int FW = 16;
    localparam int AW = 12;
    localparam int SW = 8;
    localparam int NSTEP = 1 << CB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [FW-1:0] cfg_fmin = '0;
    logic [FW-1:0] cfg_fstep = '0;
    logic [SW-1:0] cfg_settle = '0;
    logic [FW-1:0] freq_code;
    logic          adc_req;
    logic          adc_valid = 1'b0;
    logic [AW-1:0] adc_amp = '0;
    logic          done;
    logic [CB-1:0] sig_code;

    res_sweep_peak #(.CODE_BITS(CB), .FREQ_W(FW), .AMP_W(AW), .SETTLE_W(SW)) uut (
        .clk(clk), .rst(rst), .start(start), .cfg_fmin(cfg_fmin),
        .cfg_fstep(cfg_fstep), .cfg_settle(cfg_settle), .freq_code(freq_code),
        .adc_req(adc_req), .adc_valid(adc_valid), .adc_amp(adc_amp),
        .done(done), .sig_code(sig_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit cmp_en = 1'b0;
    int done_cnt = 0;

    // ADC responder controls
    int resp_k = 0;
    int lat = 0;
    bit spur_en = 1'b0;
    int amp_tab [NSTEP];

    // behavioural reference model
    int m_st = 0;        // 0 idle, 1 settling, 2 waiting for sample
    int m_cnt = 0, m_step = 0, m_fstep = 0, m_settle = 0;
    int m_best = 0, m_bidx = 0;
    int m_freq = 0, m_code = 0;
    bit m_done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_freq = 0; m_code = 0; m_done = 0; m_step = 0;
        end else begin
            m_done = 0;
            if (m_st == 0) begin
                if (start) begin
                    m_st = 1; m_step = 0; m_freq = int'(cfg_fmin);
                    m_fstep = int'(cfg_fstep); m_settle = int'(cfg_settle);
                    m_cnt = m_settle;
                end
            end else if (m_st == 1) begin
                if (m_cnt == 0) m_st = 2;
                else m_cnt--;
            end else begin
                if (adc_valid) begin
                    if (m_step == 0 || int'(adc_amp) > m_best) begin
                        m_best = int'(adc_amp); m_bidx = m_step;
                    end
                    if (m_step == NSTEP - 1) begin
                        m_st = 0; m_done = 1; m_code = m_bidx;
                    end else begin
                        m_step++; m_freq = (m_freq + m_fstep) % (1 << FW);
                        m_cnt = m_settle; m_st = 1;
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cmp_en) begin
                if (done) done_cnt++;
                chk(int'(freq_code) == m_freq, "R2", freq_code, m_freq);
                chk(adc_req == (m_st == 2), "R3", adc_req, (m_st == 2));
                chk(done == m_done, "R7", done, m_done);
                chk(int'(sig_code) == m_code, "R8", sig_code, m_code);
            end
        end
    end

    // ADC responder
    initial begin
        bit real_pulse;
        int waitc;
        real_pulse = 1'b0;
        waitc = 0;
        forever begin
            @(negedge clk);
            if (real_pulse) begin
                adc_valid = 1'b0;
                resp_k++;
                real_pulse = 1'b0;
                waitc = 0;
            end else if (adc_req) begin
                if (waitc >= lat) begin
                    adc_valid = 1'b1;
                    adc_amp = AW'(amp_tab[resp_k % NSTEP]);
                    real_pulse = 1'b1;
                end else begin
                    adc_valid = 1'b0;
                    waitc++;
                end
            end else begin
                adc_valid = spur_en;
                adc_amp = {AW{1'b1}};
            end
        end
    end

    function automatic int peak_of();
        int b = 0;
        int bi = 0;
        for (int i = 0; i < NSTEP; i++) begin
            if (i == 0 || amp_tab[i] > b) begin
                b = amp_tab[i];
                bi = i;
            end
        end
        return bi;
    endfunction

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // mode: 0 plain, 1 extra starts mid-sweep, 2 start held through end, 3 cfg change mid-sweep
    task automatic run_sweep(input int fmin, input int fstep, input int settle,
                             input int latency, input bit spur, input int mode,
                             input string req);
        int d0;
        int exp_code;
        exp_code = peak_of();
        lat = latency;
        spur_en = spur;
        resp_k = 0;
        cfg_fmin = FW'(fmin);
        cfg_fstep = FW'(fstep);
        cfg_settle = SW'(settle);
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1;
        if (mode == 2) begin
            wait_done();
            @(negedge clk);
            start = 1'b0;
            wait_done();
        end else begin
            @(negedge clk);
            start = 1'b0;
            if (mode == 1) begin
                repeat (7) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                repeat (11) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end else if (mode == 3) begin
                while (resp_k < 3) @(negedge clk);
                cfg_fmin = FW'(fmin + 100);
                cfg_fstep = FW'(fstep + 7);
                cfg_settle = SW'(settle + 3);
            end
            wait_done();
        end
        chk(int'(sig_code) == exp_code, req, sig_code, exp_code);
        @(negedge clk);
        chk(done_cnt - d0 == ((mode == 2) ? 2 : 1), "R9", done_cnt - d0, (mode == 2) ? 2 : 1);
        chk(done == 1'b0, "R7", done, 0);
        spur_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(freq_code == '0, "R1", freq_code, 0);
        chk(adc_req == 1'b0, "R1", adc_req, 0);
        chk(done == 1'b0, "R1", done, 0);
        chk(sig_code == '0, "R1", sig_code, 0);
        cmp_en = 1'b1;

        // R5: single peak in the middle
        for (int i = 0; i < NSTEP; i++) amp_tab[i] = (i == 5) ? 900 : 100 + i;
        run_sweep(1000, 25, 0, 0, 1'b0, 0, "R5");

        // R6: peak at the first step gives zero
        for (int i = 0; i < NSTEP; i++) amp_tab[i] = 1000 - i * 10;
        run_sweep(200, 3, 2, 1, 1'b0, 0, "R6");

        // R6 / R4: peak at the last step, stray valid during settle ignored, stalls
        for (int i = 0; i < NSTEP; i++) amp_tab[i] = 100 + i * 50;
        run_sweep(65520, 3, 1, 3, 1'b1, 0, "R6");

        // R5 tie keeps lower index; R9 starts mid-sweep ignored
        for (int i = 0; i < NSTEP; i++) amp_tab[i] = (i == 3 || i == 11) ? 2000 : 50 + i;
        run_sweep(40, 9, 0, 2, 1'b0, 1, "R5");

        // R9: start held across final acceptance and the done cycle
        for (int i = 0; i < NSTEP; i++) amp_tab[i] = (i == 9) ? 3000 : 700;
        run_sweep(500, 1, 1, 0, 1'b1, 2, "R9");

        // R10: configuration changed mid-sweep
        for (int i = 0; i < NSTEP; i++) amp_tab[i] = (i == 12) ? 1500 : 400 + i;
        run_sweep(7, 40, 2, 1, 1'b0, 3, "R10");

        // R8: code still held long after the sweep
        repeat (10) @(negedge clk);
        chk(int'(sig_code) == 12, "R8", sig_code, 12);

        cmp_en = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule